// File: doc/BRIEF.md
# APB Dual Countdown Timer

This block is a peripheral slave on an APB-style bus that holds two independent countdown channels inside one 4 KB register window. Each channel has a reload register, a live count, a control word selecting run, one-shot, 16/32-bit width, clock division and interrupt enable, and a raw interrupt flag that software clears by writing to a dedicated offset. The block drives one interrupt line per channel and a third line that is the OR of the two.

Two extra registers near the top of the window let a test program take over the interrupt lines: once the override is enabled, the channel lines follow two bits written by software and not the counters. A small block of read-only identification words sits at the end of the window. Every transfer completes in two cycles with no wait states. Unmapped offsets read as zero and ignore writes. Byte lanes not enabled in a write are stored as zero.

Top module: `twin_timer_apb`

## Requirements
- R1: Offsets below 0x40 belong to the channels, with address bit 5 choosing channel 0 or 1; inside a channel the word at +0x00 is the reload (writing it also loads the count), +0x04 the live count, +0x08 control, +0x0C interrupt clear, +0x10 raw flag (bit 0), +0x14 masked flag (bit 0), +0x18 the reload written without touching the count.
- R2: Control bit 0 selects one-shot, bit 1 selects 32-bit counting, bits 3:2 choose division by 1 (0), 16 (1) or 256 (2 and 3), bit 5 enables the interrupt, bit 6 selects periodic reload, bit 7 runs the channel; bit 4 and bits 31:8 read as zero. After reset control reads 0x20, the count 0xFFFFFFFF and the reload 0.
- R3: A write of any value to the interrupt-clear offset clears that channel's raw flag; a count expiry in the same cycle keeps the flag set.
- R4: On each division tick of a running channel the count drops by one; the step from 1 to 0 sets the raw flag; a tick at 0 reloads from the reload register in periodic mode or from all ones in free-running mode, and in one-shot mode the count stays at 0.
- R5: In 16-bit mode only the low 16 bits of the count change and the upper 16 bits hold; the reload register always reads back its full 32-bit value.
- R6: Writing the reload-and-count offset sets both the reload and the count to the written value and restarts clock division; writing the background reload offset changes only the reload.
- R7: The masked flag and the channel interrupt line equal raw flag AND interrupt enable; the combined line is the OR of both channel lines.
- R8: Bit 0 of the word at 0xF00 enables interrupt override; while set, channel 0 and 1 lines follow bits 0 and 1 of the word at 0xF04. Both reset to zero; 0xF00 reads back bit 0, 0xF04 reads as zero.
- R9: Words 0xFD0 through 0xFFC read, in address order, the bytes 0x04, 0x00, 0x00, 0x00, 0x23, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in bits 7:0.
- R10: Reads of unmapped offsets (including +0x1C of each channel, 0x40 to 0xEFC, 0xF08 to 0xFCC) return zero, and writes there change nothing.
- R11: Write byte lanes whose strobe is low are stored as zero; the ready output is always high so each transfer takes two cycles.
- R12: With division by N selected, the first count change comes N cycles after the cycle whose edge sets the run bit, and later changes every N cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 12 | Byte address inside the window |
| pwdata | input | 32 | Write data |
| pstrb | input | 4 | Byte lane enables for writes |
| prdata | output | 32 | Read data, valid while selected for a read |
| pready | output | 1 | Always high |
| irq_ch0 | output | 1 | Channel 0 interrupt |
| irq_ch1 | output | 1 | Channel 1 interrupt |
| irq_any | output | 1 | OR of both channel interrupts |

## Verification
Assertions watch, on every cycle, that a clear without a coinciding expiry drops the raw flag, that an expiry sets it, that a parked one-shot count and the upper half of a 16-bit count do not move, that divide-by-16 ticks never come back to back, that override writes reach the lines one cycle later and that unmapped reads return zero. The bench alone shows the exact tick timing after a run edge, the reload values chosen in each mode, byte-lane padding, the identification bytes and the interaction of both channels under long random register traffic compared with a bench-side model.

// File: rtl/dtm_pkg.sv
// Shared constants and types for the dual countdown timer.
// Assumes a 32-bit data path; control bit positions are fixed by software.
package dtm_pkg;
    localparam int DW = 32;

    localparam int CB_ONESHOT  = 0;
    localparam int CB_WIDE     = 1;
    localparam int CB_PS_LO    = 2;
    localparam int CB_INTEN    = 5;
    localparam int CB_PERIODIC = 6;
    localparam int CB_RUN      = 7;

    localparam logic [DW-1:0] CTRL_KEEP = 32'h0000_00EF;
    localparam logic [DW-1:0] CTRL_INIT = 32'h0000_0020;

    typedef enum logic [2:0] {
        CR_RELOAD  = 3'd0,
        CR_COUNT   = 3'd1,
        CR_CTRL    = 3'd2,
        CR_ICLR    = 3'd3,
        CR_RAW     = 3'd4,
        CR_MASKED  = 3'd5,
        CR_BGLOAD  = 3'd6,
        CR_NONE    = 3'd7
    } chreg_e;

    typedef struct packed {
        logic reload;
        logic bgload;
        logic ctrl;
        logic iclr;
    } chwr_t;
endpackage

// File: rtl/dtm_prescaler.sv
// Clock divider for one channel: emits a one-cycle tick every 1, 2**MID_LOG
// or 2**HIGH_LOG cycles. Assumes sel 3 behaves like sel 2. Counter is held
// at zero while the channel is stopped or on restart.
module dtm_prescaler #(
    parameter int MID_LOG  = 4,
    parameter int HIGH_LOG = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic       restart,
    input  logic [1:0] sel,
    output logic       tick
);
    logic [HIGH_LOG-1:0] cnt;

    // Division counter: free-running while the channel runs
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (!run || restart)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    // Tick decode for the selected division
    always_comb begin
        case (sel)
            2'd0:    tick = run;
            2'd1:    tick = run && (&cnt[MID_LOG-1:0]);
            default: tick = run && (&cnt);
        endcase
    end

    AST_MID_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && sel == 2'd1) |=> (!tick || sel == 2'd0)); // R12
endmodule

// File: rtl/dtm_channel.sv
// One countdown channel: reload, live count, control word and raw flag.
// Assumes writes arrive as single-cycle strobes already decoded by the
// wrapper. The low NW bits count in narrow mode, the rest hold.
module dtm_channel
    import dtm_pkg::*;
#(
    parameter int NW       = 16,
    parameter int MID_LOG  = 4,
    parameter int HIGH_LOG = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  chwr_t         wr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] reload_q,
    output logic [DW-1:0] count_q,
    output logic [DW-1:0] ctrl_q,
    output logic          raw_q,
    output logic          irq
);
    logic          run, wide, oneshot, periodic, tick;
    logic [DW-1:0] cur, src, stepped, merged;
    logic          at_one, at_zero, expire;

    assign run      = ctrl_q[CB_RUN];
    assign wide     = ctrl_q[CB_WIDE];
    assign oneshot  = ctrl_q[CB_ONESHOT];
    assign periodic = ctrl_q[CB_PERIODIC];

    dtm_prescaler #(.MID_LOG(MID_LOG), .HIGH_LOG(HIGH_LOG)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (run),
        .restart (wr.reload),
        .sel     (ctrl_q[CB_PS_LO +: 2]),
        .tick    (tick)
    );

    // Next count value for a tick, honouring width and reload mode
    always_comb begin
        cur     = wide ? count_q : {{(DW-NW){1'b0}}, count_q[NW-1:0]};
        at_one  = (cur == {{(DW-1){1'b0}}, 1'b1});
        at_zero = (cur == '0);
        src     = periodic ? reload_q : '1;
        stepped = at_zero ? src : cur - 1'b1;
        merged  = wide ? stepped : {count_q[DW-1:NW], stepped[NW-1:0]};
        expire  = tick && at_one && !wr.reload;
    end

    // Live count: software load first, then tick-driven stepping
    always_ff @(posedge clk) begin
        if (!rst_n)
            count_q <= '1;
        else if (wr.reload)
            count_q <= wdata;
        else if (tick && !(at_zero && oneshot))
            count_q <= merged;
    end

    // Reload register written by either reload offset
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '0;
        else if (wr.reload || wr.bgload)
            reload_q <= wdata;
    end

    // Control word with unused bits forced to zero
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_INIT;
        else if (wr.ctrl)
            ctrl_q <= wdata & CTRL_KEEP;
    end

    // Raw flag: expiry sets and wins over a clear
    always_ff @(posedge clk) begin
        if (!rst_n)
            raw_q <= 1'b0;
        else if (expire)
            raw_q <= 1'b1;
        else if (wr.iclr)
            raw_q <= 1'b0;
    end

    assign irq = raw_q && ctrl_q[CB_INTEN];

    AST_CLEAR_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (wr.iclr && !tick) |=> !raw_q); // R3
    AST_EXPIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && at_one && !wr.reload) |=> raw_q); // R4
    AST_ONESHOT_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        (run && oneshot && at_zero && !wr.reload) |=> (count_q == $past(count_q))); // R4
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && !wr.reload) |=> (count_q[DW-1:NW] == $past(count_q[DW-1:NW]))); // R5
endmodule

// File: rtl/dtm_id_rom.sv
// Identification byte table indexed by word; entries past the table read 0.
module dtm_id_rom (
    input  logic [3:0] idx,
    output logic [7:0] id_byte
);
    // Fixed identification bytes in word order
    always_comb begin
        case (idx)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = 8'h23;
            4'd5:    id_byte = 8'hB8;
            4'd6:    id_byte = 8'h1B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    end
endmodule

// File: rtl/twin_timer_apb.sv
// Bus wrapper for two countdown channels in one 4 KB window. Decodes the
// access phase of each transfer, pads unstrobed bytes with zero, muxes read
// data with no wait state, and applies the interrupt override.
// Assumes word-aligned addresses; paddr[1:0] are ignored.
module twin_timer_apb
    import dtm_pkg::*;
#(
    parameter int AW       = 12,
    parameter int NW       = 16,
    parameter int MID_LOG  = 4,
    parameter int HIGH_LOG = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    input  logic [3:0]    pstrb,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          irq_ch0,
    output logic          irq_ch1,
    output logic          irq_any
);
    localparam int NCH   = 2;
    localparam int NLANE = DW / 8;
    localparam logic [AW-1:0] OFS_OVR_EN  = AW'(12'hF00);
    localparam logic [AW-1:0] OFS_OVR_VAL = AW'(12'hF04);
    localparam logic [AW-1:0] OFS_ID_LO   = AW'(12'hFD0);
    localparam logic [AW-1:0] OFS_ID_HI   = AW'(12'hFFC);

    logic          acc, wr_acc;
    logic [DW-1:0] wdata_eff;
    logic          in_chan, chan_bit, is_ovr_en, is_ovr_val, is_id;
    chreg_e        creg;
    logic [AW-1:0] id_off;
    logic [7:0]    id_byte;
    logic          ovr_en_q;
    logic [NCH-1:0] ovr_val_q;
    logic [DW-1:0] rd_mux;
    logic [NCH-1:0] irq_line;
    logic          unused_addr;

    logic [DW-1:0] reload_a [NCH];
    logic [DW-1:0] count_a  [NCH];
    logic [DW-1:0] ctrl_a   [NCH];
    logic [NCH-1:0] raw_a;
    logic [NCH-1:0] irq_a;

    assign acc         = psel && penable;
    assign wr_acc      = acc && pwrite;
    assign pready      = 1'b1;
    assign unused_addr = ^paddr[1:0];

    // Zero-pad byte lanes whose strobe is low
    genvar b;
    generate
        for (b = 0; b < NLANE; b++) begin : g_lane
            assign wdata_eff[8*b +: 8] = pwdata[8*b +: 8] & {8{pstrb[b]}};
        end
    endgenerate

    // Address decode of the window regions
    always_comb begin
        in_chan    = (paddr[AW-1:6] == '0);
        chan_bit   = paddr[5];
        creg       = chreg_e'(paddr[4:2]);
        is_ovr_en  = (paddr[AW-1:2] == OFS_OVR_EN[AW-1:2]);
        is_ovr_val = (paddr[AW-1:2] == OFS_OVR_VAL[AW-1:2]);
        is_id      = (paddr[AW-1:2] >= OFS_ID_LO[AW-1:2]) &&
                     (paddr[AW-1:2] <= OFS_ID_HI[AW-1:2]);
        id_off     = paddr - OFS_ID_LO;
    end

    dtm_id_rom u_id (
        .idx     (id_off[5:2]),
        .id_byte (id_byte)
    );

    // Channel instances with per-channel write strobes
    genvar c;
    generate
        for (c = 0; c < NCH; c++) begin : g_ch
            chwr_t hit;
            logic  sel_me;
            assign sel_me     = wr_acc && in_chan && (chan_bit == 1'(c));
            assign hit.reload = sel_me && (creg == CR_RELOAD);
            assign hit.bgload = sel_me && (creg == CR_BGLOAD);
            assign hit.ctrl   = sel_me && (creg == CR_CTRL);
            assign hit.iclr   = sel_me && (creg == CR_ICLR);

            dtm_channel #(.NW(NW), .MID_LOG(MID_LOG), .HIGH_LOG(HIGH_LOG)) u_ch (
                .clk      (clk),
                .rst_n    (rst_n),
                .wr       (hit),
                .wdata    (wdata_eff),
                .reload_q (reload_a[c]),
                .count_q  (count_a[c]),
                .ctrl_q   (ctrl_a[c]),
                .raw_q    (raw_a[c]),
                .irq      (irq_a[c])
            );
        end
    endgenerate

    // Override enable register
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_en_q <= 1'b0;
        else if (wr_acc && is_ovr_en)
            ovr_en_q <= wdata_eff[0];
    end

    // Override value register (write-only)
    always_ff @(posedge clk) begin
        if (!rst_n)
            ovr_val_q <= '0;
        else if (wr_acc && is_ovr_val)
            ovr_val_q <= wdata_eff[NCH-1:0];
    end

    // Read data multiplexer
    always_comb begin
        rd_mux = '0;
        if (in_chan) begin
            case (creg)
                CR_RELOAD, CR_BGLOAD: rd_mux = reload_a[chan_bit];
                CR_COUNT:             rd_mux = count_a[chan_bit];
                CR_CTRL:              rd_mux = ctrl_a[chan_bit];
                CR_RAW:               rd_mux = {{(DW-1){1'b0}}, raw_a[chan_bit]};
                CR_MASKED:            rd_mux = {{(DW-1){1'b0}}, irq_a[chan_bit]};
                default:              rd_mux = '0;
            endcase
        end else if (is_ovr_en) begin
            rd_mux = {{(DW-1){1'b0}}, ovr_en_q};
        end else if (is_id) begin
            rd_mux = {{(DW-8){1'b0}}, id_byte};
        end
    end

    assign prdata = (psel && !pwrite) ? rd_mux : '0;

    // Interrupt line selection between counters and override
    assign irq_line = ovr_en_q ? ovr_val_q : irq_a;
    assign irq_ch0  = irq_line[0];
    assign irq_ch1  = irq_line[1];
    assign irq_any  = |irq_line;

    AST_OVR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_acc && is_ovr_val && ovr_en_q) |=>
        (irq_ch0 == $past(wdata_eff[0]) && irq_ch1 == $past(wdata_eff[1]))); // R8
    AST_LINE_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_en_q && (irq_ch0 || irq_ch1)) |-> (raw_a != '0)); // R7
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (acc && !pwrite && !in_chan && !is_ovr_en && !is_id) |-> (prdata == '0)); // R10
endmodule

// File: tb/test_twin_timer_apb.sv
module test_twin_timer_apb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [3:0]  pstrb = '0;
    logic [31:0] prdata;
    logic        pready, irq_ch0, irq_ch1, irq_any;

    int nvec = 0, nfail = 0, cyc = 0;
    bit done = 0;

    // bench model state
    logic [31:0] m_ld [2];
    logic [31:0] m_val [2];
    logic [31:0] m_ctl [2];
    logic        m_raw [2];
    int          m_pc [2];
    logic        m_ovr_en;
    logic [1:0]  m_ovr_val;

    twin_timer_apb i_twin_timer_apb (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb),
        .prdata(prdata), .pready(pready), .irq_ch0(irq_ch0),
        .irq_ch1(irq_ch1), .irq_any(irq_any)
    );

    always #2 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] id_exp(input int i);
        case (i)
            0: return 8'h04;  4: return 8'h23;  5: return 8'hB8;
            6: return 8'h1B;  8: return 8'h0D;  9: return 8'hF0;
            10: return 8'h05; 11: return 8'hB1;
            default: return 8'h00;
        endcase
    endfunction

    function automatic logic [31:0] exp_read(input logic [11:0] a);
        int c;
        if (a < 12'h040) begin
            c = a[5];
            case (a[4:2])
                3'd0, 3'd6: return m_ld[c];
                3'd1: return m_val[c];
                3'd2: return m_ctl[c];
                3'd4: return {31'b0, m_raw[c]};
                3'd5: return {31'b0, m_raw[c] & m_ctl[c][5]};
                default: return 32'h0;
            endcase
        end
        if (a[11:2] == 10'h3C0) return {31'b0, m_ovr_en};
        if (a >= 12'hFD0) return {24'b0, id_exp((int'(a) - 'hFD0) / 4)};
        return 32'h0;
    endfunction

    function automatic logic exp_irq(input int c);
        return m_ovr_en ? m_ovr_val[c] : (m_raw[c] & m_ctl[c][5]);
    endfunction

    // Model: one clock step from the requirements, using pre-edge state
    always @(posedge clk) begin
        logic [31:0] w, cur, nv;
        logic acc, wr, tick, ldw, bgw, ctw, clw, hit, wide;
        if (!rst_n) begin
            for (int c = 0; c < 2; c++) begin
                m_ld[c] = 32'h0; m_val[c] = 32'hFFFF_FFFF; m_ctl[c] = 32'h20;
                m_raw[c] = 1'b0; m_pc[c] = 0;
            end
            m_ovr_en = 1'b0; m_ovr_val = 2'b0;
        end else begin
            acc = psel && penable;
            wr = acc && pwrite;
            for (int k = 0; k < 4; k++) w[8*k +: 8] = pstrb[k] ? pwdata[8*k +: 8] : 8'h00;
            for (int c = 0; c < 2; c++) begin
                hit  = wr && (paddr < 12'h040) && (paddr[5] == c[0]);
                ldw  = hit && paddr[4:2] == 3'd0;
                ctw  = hit && paddr[4:2] == 3'd2;
                clw  = hit && paddr[4:2] == 3'd3;
                bgw  = hit && paddr[4:2] == 3'd6;
                tick = m_ctl[c][7] && ((m_ctl[c][3:2] == 2'd0) ||
                       (m_ctl[c][3:2] == 2'd1 && (m_pc[c] % 16) == 15) ||
                       (m_ctl[c][3] && m_pc[c] == 255));
                wide = m_ctl[c][1];
                cur  = wide ? m_val[c] : {16'h0, m_val[c][15:0]};
                nv   = m_val[c];
                if (ldw) nv = w;
                else if (tick) begin
                    logic [31:0] st;
                    logic skip;
                    skip = 1'b0;
                    if (cur == 0) begin
                        if (m_ctl[c][0]) skip = 1'b1;
                        st = m_ctl[c][6] ? m_ld[c] : 32'hFFFF_FFFF;
                    end else st = cur - 1;
                    if (!skip) nv = wide ? st : {m_val[c][31:16], st[15:0]};
                end
                if (tick && cur == 1 && !ldw) m_raw[c] = 1'b1;
                else if (clw) m_raw[c] = 1'b0;
                m_pc[c] = (!m_ctl[c][7] || ldw) ? 0 : (m_pc[c] + 1) % 256;
                m_val[c] = nv;
                if (ldw || bgw) m_ld[c] = w;
                if (ctw) m_ctl[c] = w & 32'hEF;
            end
            if (wr && paddr[11:2] == 10'h3C0) m_ovr_en = w[0];
            if (wr && paddr[11:2] == 10'h3C1) m_ovr_val = w[1:0];
        end
    end

    task automatic check_irq();
        chk("R7", {29'b0, irq_ch0, irq_ch1, irq_any},
            {29'b0, exp_irq(0), exp_irq(1), exp_irq(0) | exp_irq(1)});
    endtask

    task automatic apb(input logic w, input logic [11:0] a, input logic [31:0] d,
                       input logic [3:0] s, input string tag, output logic [31:0] rd);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d; pstrb = s;
        #1 check_irq();
        @(negedge clk);
        penable = 1'b1;
        #1;
        rd = prdata;
        chk("R11", {31'b0, pready}, 32'h1);
        if (!w) chk(tag, rd, exp_read(a));
        check_irq();
    endtask

    task automatic wr32(input logic [11:0] a, input logic [31:0] d);
        logic [31:0] rd;
        apb(1'b1, a, d, 4'hF, "W", rd);
    endtask

    task automatic rd_lit(input logic [11:0] a, input logic [31:0] exp, input string tag);
        logic [31:0] rd;
        apb(1'b0, a, 32'h0, 4'h0, tag, rd);
        chk(tag, rd, exp);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            psel = 1'b0; penable = 1'b0;
            #1 check_irq();
        end
    endtask

    // Watchdog: a hung run counts as a failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1;
            nfail++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd, d;
        logic [11:0] a;
        logic [3:0]  s;
        logic        w;
        int pick, ch, r;
        void'($urandom(32'd20240611));

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd_lit(12'h008, 32'h20, "R2 ctrl reset");
        rd_lit(12'h028, 32'h20, "R2 ctrl reset ch1");
        rd_lit(12'h004, 32'hFFFF_FFFF, "R2 count reset");
        rd_lit(12'h000, 32'h0, "R2 reload reset");
        rd_lit(12'h010, 32'h0, "R3 raw reset");
        rd_lit(12'hF00, 32'h0, "R8 override reset");
        chk("R7 lines after reset", {29'b0, irq_ch0, irq_ch1, irq_any}, 32'h0);

        // identification words
        for (int i = 0; i < 12; i++)
            rd_lit(12'hFD0 + 12'(4 * i), {24'h0, id_exp(i)}, "R9 id");

        // unmapped offsets
        rd_lit(12'h01C, 32'h0, "R10 gap ch0");
        rd_lit(12'h03C, 32'h0, "R10 gap ch1");
        rd_lit(12'h040, 32'h0, "R10 above channels");
        rd_lit(12'h800, 32'h0, "R10 middle");
        rd_lit(12'hF08, 32'h0, "R10 after override");
        rd_lit(12'hFCC, 32'h0, "R10 before id");
        wr32(12'h01C, 32'hDEAD_BEEF);
        wr32(12'h800, 32'h1234_5678);
        rd_lit(12'h000, 32'h0, "R10 write ignored reload");
        rd_lit(12'h008, 32'h20, "R10 write ignored ctrl");

        // byte strobes and background reload
        apb(1'b1, 12'h018, 32'hAABB_CCDD, 4'b0101, "W", rd);
        rd_lit(12'h018, 32'h00BB_00DD, "R11 strobe padding");
        rd_lit(12'h004, 32'hFFFF_FFFF, "R6 bgload leaves count");
        rd_lit(12'h038, 32'h0, "R1 other channel untouched");

        // control masking
        wr32(12'h008, 32'hFFFF_FFFF);
        rd_lit(12'h008, 32'hEF, "R2 ctrl mask");
        wr32(12'h008, 32'h20);

        // one-shot expiry on ch0, divide by 1, 32-bit
        wr32(12'h000, 32'h3);
        rd_lit(12'h004, 32'h3, "R6 reload sets count");
        wr32(12'h008, 32'hA3);
        idle(6);
        rd_lit(12'h004, 32'h0, "R4 one-shot parks at zero");
        rd_lit(12'h010, 32'h1, "R4 raw set on expiry");
        rd_lit(12'h014, 32'h1, "R7 masked flag");
        chk("R7 line ch0", {30'b0, irq_ch0, irq_any}, 32'h3);
        wr32(12'h00C, 32'h0);
        rd_lit(12'h010, 32'h0, "R3 clear raw");
        chk("R3 line dropped", {31'b0, irq_ch0}, 32'h0);

        // periodic 16-bit on ch0
        wr32(12'h008, 32'h20);
        wr32(12'h000, 32'h1234_0005);
        wr32(12'h008, 32'hE0);
        rd_lit(12'h000, 32'h1234_0005, "R5 reload full width");
        idle(20);
        apb(1'b0, 12'h004, 32'h0, 4'h0, "R5 count", rd);
        chk("R5 upper half held", {16'h0, rd[31:16]}, 32'h1234);
        rd_lit(12'h010, 32'h1, "R4 periodic re-expiry");
        wr32(12'h008, 32'h20);
        wr32(12'h00C, 32'h0);

        // interrupt override
        wr32(12'hF00, 32'h1);
        wr32(12'hF04, 32'h2);
        idle(1);
        chk("R8 override 2", {29'b0, irq_ch0, irq_ch1, irq_any}, 32'h3);
        rd_lit(12'hF04, 32'h0, "R8 override value reads zero");
        rd_lit(12'hF00, 32'h1, "R8 override enable reads back");
        wr32(12'hF04, 32'h1);
        idle(1);
        chk("R8 override 1", {29'b0, irq_ch0, irq_ch1, irq_any}, 32'h5);
        wr32(12'hF00, 32'h0);
        idle(1);
        chk("R8 override off", {29'b0, irq_ch0, irq_ch1, irq_any}, 32'h0);

        // divide-by-16 timing on ch1
        wr32(12'h028, 32'h0);
        wr32(12'h020, 32'h2);
        wr32(12'h028, 32'hA7);
        idle(14);
        rd_lit(12'h024, 32'h2, "R12 no step before 16 cycles");
        rd_lit(12'h024, 32'h1, "R12 first step at 16 cycles");
        wr32(12'h028, 32'h20);

        // random traffic against the model
        for (int n = 0; n < 2500; n++) begin
            pick = $urandom % 16;
            ch = $urandom % 2;
            r = $urandom % 8;
            a = {6'b0, ch[0], r[2:0], 2'b00};
            d = $urandom;
            if (r == 0 || r == 6) d = ($urandom % 4 == 0) ? d : ($urandom % 8);
            if (r == 2 && ($urandom % 4 != 0)) d[3:2] = 2'b00;
            if (pick == 13) begin a = 12'hF00; d = ($urandom % 6 == 0) ? 32'h1 : 32'h0; end
            if (pick == 14) a = 12'hF04;
            if (pick == 15) a = {10'($urandom % 1024), 2'b00};
            w = $urandom % 2;
            s = ($urandom % 4 == 0) ? 4'($urandom % 16) : 4'hF;
            apb(w, a, d, s, "R1 random read", rd);
        end
        idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end
endmodule